// File: doc/BRIEF.md
# Microcontroller reset and wake-up controller

This block decides how a small microcontroller core comes out of reset. It watches an active-low external reset pin, an active-low power-good signal, a single-cycle watchdog time-out pulse and a request from the core to enter its HALT (sleep) state. From these it produces three controls. The first is a cold reset level that the program counter, stack pointer, interrupt enable, prescaler and divider, watchdog, real-time clock, time-base, timer/event counter and I/O port direction logic all consume. The second is a warm reset level that only the program counter and stack pointer consume. The third is a core-enable that stalls the core while the oscillator settles.

A start-up hold of `SU_CYCLES` clocks (1024 by default) runs after power-up and after every wake-up from HALT. A watchdog time-out while the core sleeps does not disturb anything beyond PC and SP. It raises warm reset for the hold period and then resumes. Two sticky status bits, a time-out flag and a power-down flag, record what caused the latest restart so that software can read it.

All pins are plain control and status levels. The block has no data stream, so there is no valid/ready handshake and no back-pressure. The consumers of cold reset release their own state when the level drops; the watchdog counter starts counting again once cold reset falls.

Top module: `rst_wake_ctrl`

## Requirements
- R1: The external pin passes through a `SYNC_STAGES`-flop synchroniser (default 2). In normal operation a pin level change acts on the third clock edge after it is first sampled: cold reset rises there on assertion, and on release cold reset falls and core_en rises on that edge, with no start-up hold.
- R2: While por_n is low, cold_rst=1, core_en=0, warm_rst=0 and both flags are 0. After por_n rises, core_en rises on the (SU_CYCLES+2)-th clock edge once the synchronised pin reads high. A pin held low at power-up restarts this count from its release.
- R3: A pin reset while running holds cold_rst=1 for as long as the pin stays low and leaves both flags unchanged.
- R4: A watchdog pulse while running gives cold_rst=1 for exactly one cycle, sets the time-out flag to 1, leaves the power-down flag unchanged, and restores core_en on the next edge.
- R5: A watchdog pulse while halted gives no cold reset. Instead, warm_rst=1 for exactly SU_CYCLES cycles, the flags become time-out=1 and power-down=1, and core_en rises SU_CYCLES edges after the pulse is sampled.
- R6: A pin reset while halted sets time-out=0 and power-down=1. cold_rst stays 1 through the pin hold and the following start-up hold. core_en rises SU_CYCLES+3 edges after the release is first sampled.
- R7: When the synchronised pin is low in the same cycle as a watchdog pulse, the pin reset wins: the outcome is that of R3 or R6, and the time-out flag does not go to 1.
- R8: halt_req sampled while running drops core_en on the next edge and enters HALT. halt_req has no effect while already halted or during a start-up hold.
- R9: Watchdog pulses have no effect during a pin hold, a start-up hold or power-up: the flags and the hold length are unchanged.
- R10: At most one of cold_rst, warm_rst and core_en is high in any cycle. All three are low while halted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-good, low while power is not yet valid; asynchronous reset of this block |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| wdt_tmo | input | 1 | Watchdog time-out, one-cycle pulse |
| halt_req | input | 1 | Core executes its HALT instruction |
| cold_rst | output | 1 | Full reset level for all core state |
| warm_rst | output | 1 | Reset level for program counter and stack pointer only |
| core_en | output | 1 | Core may execute; low during any reset, hold or HALT |
| to_flag | output | 1 | Time-out status flag |
| pdf_flag | output | 1 | Power-down status flag |

## Verification
The hardest case to reach is a watchdog pulse landing on the very cycle in which the synchronised pin first reads low. The pin lags its port by two edges, so a bench that drives both together never tests the priority. The stimulus lowers the pin, waits exactly two edges, and then pulses the watchdog for the third, both while running and while halted. The sweep visits every combination of running or halted context with pin, watchdog or both. It repeats the sweep so that each event starts from several different flag values. The flag model is updated arithmetically after each event, and the exact edge count to core_en is compared with SU_CYCLES-based formulas.

// File: rtl/rwc_pkg.sv
package rwc_pkg;

  typedef enum logic [2:0] {
    ST_POWER_ON   = 3'd0,
    ST_RUN        = 3'd1,
    ST_HALT       = 3'd2,
    ST_WAKE_DELAY = 3'd3,
    ST_RESET_HOLD = 3'd4
  } rwc_state_e;

endpackage

// File: rtl/rwc_sync.sv
module rwc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  // reset value 0: pin treated as asserted until it is seen high
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain <= '0;
    else         chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/rwc_su_timer.sv
module rwc_su_timer #(
  parameter int SU_CYCLES = 1024
) (
  input  logic clk,
  input  logic arst_n,
  input  logic clr,
  input  logic en,
  output logic done
);

  localparam int CW = (SU_CYCLES > 1) ? $clog2(SU_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(SU_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)  cnt <= '0;
    else if (clr) cnt <= '0;
    else if (en)  cnt <= cnt + CW'(1);
  end

  assign done = en && (cnt == LAST);

endmodule

// File: rtl/rwc_fsm.sv
module rwc_fsm
  import rwc_pkg::*;
(
  input  logic clk,
  input  logic arst_n,
  input  logic pin_ok,
  input  logic wdt_tmo,
  input  logic halt_req,
  input  logic tmr_done,
  output logic tmr_clr,
  output logic tmr_en,
  output logic cold_rst,
  output logic warm_rst,
  output logic core_en,
  output logic to_flag,
  output logic pdf_flag
);

  rwc_state_e st, st_n;
  logic need_su, need_su_n;
  logic wake_cold, wake_cold_n;
  logic to_q, to_n, pdf_q, pdf_n;

  always_comb begin
    st_n        = st;
    need_su_n   = need_su;
    wake_cold_n = wake_cold;
    to_n        = to_q;
    pdf_n       = pdf_q;
    case (st)
      ST_POWER_ON: begin
        if (tmr_done) st_n = ST_RUN;
      end
      ST_RUN: begin
        if (!pin_ok) begin
          st_n      = ST_RESET_HOLD;
          need_su_n = 1'b0;
        end else if (wdt_tmo) begin
          st_n      = ST_RESET_HOLD;
          need_su_n = 1'b0;
          to_n      = 1'b1;
        end else if (halt_req) begin
          st_n = ST_HALT;
        end
      end
      ST_HALT: begin
        if (!pin_ok) begin
          st_n      = ST_RESET_HOLD;
          need_su_n = 1'b1;
          to_n      = 1'b0;
          pdf_n     = 1'b1;
        end else if (wdt_tmo) begin
          st_n        = ST_WAKE_DELAY;
          wake_cold_n = 1'b0;
          to_n        = 1'b1;
          pdf_n       = 1'b1;
        end
      end
      ST_WAKE_DELAY: begin
        if (!pin_ok) begin
          st_n      = ST_RESET_HOLD;
          need_su_n = 1'b1;
        end else if (tmr_done) begin
          st_n = ST_RUN;
        end
      end
      ST_RESET_HOLD: begin
        if (pin_ok) begin
          if (need_su) begin
            st_n        = ST_WAKE_DELAY;
            wake_cold_n = 1'b1;
          end else begin
            st_n = ST_RUN;
          end
        end
      end
      default: st_n = ST_POWER_ON;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st        <= ST_POWER_ON;
      need_su   <= 1'b1;
      wake_cold <= 1'b1;
      to_q      <= 1'b0;
      pdf_q     <= 1'b0;
    end else begin
      st        <= st_n;
      need_su   <= need_su_n;
      wake_cold <= wake_cold_n;
      to_q      <= to_n;
      pdf_q     <= pdf_n;
    end
  end

  assign tmr_clr  = (st_n != st) || ((st == ST_POWER_ON) && !pin_ok);
  assign tmr_en   = ((st == ST_POWER_ON) && pin_ok) || (st == ST_WAKE_DELAY);
  assign cold_rst = (st == ST_POWER_ON) || (st == ST_RESET_HOLD) ||
                    ((st == ST_WAKE_DELAY) && wake_cold);
  assign warm_rst = (st == ST_WAKE_DELAY) && !wake_cold;
  assign core_en  = (st == ST_RUN);
  assign to_flag  = to_q;
  assign pdf_flag = pdf_q;

endmodule

// File: rtl/rst_wake_ctrl.sv
module rst_wake_ctrl #(
  parameter int SU_CYCLES   = 1024,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic ext_rst_n,
  input  logic wdt_tmo,
  input  logic halt_req,
  output logic cold_rst,
  output logic warm_rst,
  output logic core_en,
  output logic to_flag,
  output logic pdf_flag
);

  logic pin_ok;
  logic tmr_clr, tmr_en, tmr_done;

  rwc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .arst_n (por_n),
    .d      (ext_rst_n),
    .q      (pin_ok)
  );

  rwc_su_timer #(.SU_CYCLES(SU_CYCLES)) u_tmr (
    .clk    (clk),
    .arst_n (por_n),
    .clr    (tmr_clr),
    .en     (tmr_en),
    .done   (tmr_done)
  );

  rwc_fsm u_fsm (
    .clk      (clk),
    .arst_n   (por_n),
    .pin_ok   (pin_ok),
    .wdt_tmo  (wdt_tmo),
    .halt_req (halt_req),
    .tmr_done (tmr_done),
    .tmr_clr  (tmr_clr),
    .tmr_en   (tmr_en),
    .cold_rst (cold_rst),
    .warm_rst (warm_rst),
    .core_en  (core_en),
    .to_flag  (to_flag),
    .pdf_flag (pdf_flag)
  );

endmodule

// File: rtl/rwc_checker.sv
module rwc_checker #(
  parameter int SU_CYCLES = 1024
) (
  input logic clk,
  input logic por_n,
  input logic pin_ok,
  input logic wdt_tmo,
  input logic cold_rst,
  input logic warm_rst,
  input logic core_en,
  input logic to_flag,
  input logic pdf_flag
);

  localparam int WW = $clog2(SU_CYCLES + 2) + 1;
  logic [WW-1:0] warm_run;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        warm_run <= '0;
    else if (warm_rst) warm_run <= warm_run + WW'(1);
    else               warm_run <= '0;
  end

  assert_excl_R10: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0({cold_rst, warm_rst, core_en}));

  assert_pin_run_R3: assert property (@(posedge clk) disable iff (!por_n)
    (core_en && !pin_ok) |=> (cold_rst && $stable({to_flag, pdf_flag})));

  assert_wdt_run_R4: assert property (@(posedge clk) disable iff (!por_n)
    (core_en && pin_ok && wdt_tmo) |=> (cold_rst && to_flag && $stable(pdf_flag)));

  assert_prio_R7: assert property (@(posedge clk) disable iff (!por_n)
    (core_en && !pin_ok && wdt_tmo) |=> $stable(to_flag));

  assert_warm_flags_R5: assert property (@(posedge clk) disable iff (!por_n)
    warm_rst |-> (to_flag && pdf_flag && !cold_rst));

  assert_warm_len_R5: assert property (@(posedge clk) disable iff (!por_n)
    warm_run <= WW'(SU_CYCLES));

  assert_flag_src_R9: assert property (@(posedge clk) disable iff (!por_n)
    !$stable({to_flag, pdf_flag}) |-> $past(!cold_rst && !warm_rst));

endmodule

bind rst_wake_ctrl rwc_checker #(.SU_CYCLES(SU_CYCLES)) u_chk (
  .clk      (clk),
  .por_n    (por_n),
  .pin_ok   (pin_ok),
  .wdt_tmo  (wdt_tmo),
  .cold_rst (cold_rst),
  .warm_rst (warm_rst),
  .core_en  (core_en),
  .to_flag  (to_flag),
  .pdf_flag (pdf_flag)
);

// File: tb/sim_rst_wake_ctrl.sv
module sim_rst_wake_ctrl;

  localparam int CLK_P = 10;
  localparam int SU    = 16;

  logic clk = 1'b0;
  logic por_n, ext_rst_n, wdt_tmo, halt_req;
  logic cold_rst, warm_rst, core_en, to_flag, pdf_flag;

  int nvec = 0;
  int nerr = 0;
  bit finished = 0;
  logic e_to = 1'b0, e_pdf = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  rst_wake_ctrl #(.SU_CYCLES(SU), .SYNC_STAGES(2)) u0 (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n), .wdt_tmo(wdt_tmo),
    .halt_req(halt_req), .cold_rst(cold_rst), .warm_rst(warm_rst),
    .core_en(core_en), .to_flag(to_flag), .pdf_flag(pdf_flag)
  );

  task automatic chk(input string req, input int act, input int exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_flags(input string req);
    chk({req, " to_flag"}, int'(to_flag), int'(e_to));
    chk({req, " pdf_flag"}, int'(pdf_flag), int'(e_pdf));
  endtask

  // counts edges until core_en is seen high; tallies samples where the
  // reset levels differ from the expected hold levels
  task automatic wait_core(input logic x_cold, input logic x_warm,
                           output int n, output int bad);
    n = 0; bad = 0;
    while (core_en !== 1'b1 && n < SU + 20) begin
      if (cold_rst !== x_cold || warm_rst !== x_warm) bad++;
      @(negedge clk);
      n++;
    end
  endtask

  // ctx 0 = running, 1 = halted; ev 0 = pin+wdt together, 1 = pin, 2 = wdt
  task automatic scenario(input int ctx, input int ev);
    int n, bad;
    string tag;
    if (ctx == 1) begin
      halt_req = 1'b1;
      @(negedge clk);
      chk("R8 halt entry core_en", int'(core_en), 0);
      @(negedge clk);              // halt_req still high while halted
      halt_req = 1'b0;
      chk("R8 halted core_en", int'(core_en), 0);
      chk("R10 halted cold", int'(cold_rst), 0);
      chk("R10 halted warm", int'(warm_rst), 0);
    end
    if (ev != 2) begin
      tag = (ev == 0) ? "R7" : (ctx == 1 ? "R6" : "R3");
      ext_rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      if (ev == 0) wdt_tmo = 1'b1;
      @(negedge clk);
      wdt_tmo = 1'b0;
      if (ctx == 1) begin e_to = 1'b0; e_pdf = 1'b1; end
      chk({tag, " R1 cold on third edge"}, int'(cold_rst), 1);
      chk_flags(tag);
      repeat (3) @(negedge clk);
      chk({tag, " cold held"}, int'(cold_rst), 1);
      if (ctx == 1) wdt_tmo = 1'b1;   // R9: ignored during holds
      ext_rst_n = 1'b1;
      wait_core(1'b1, 1'b0, n, bad);
      wdt_tmo = 1'b0;
      chk({tag, " R1 release edges"}, n, (ctx == 1) ? SU + 3 : 3);
      chk({tag, " cold through hold"}, bad, 0);
      chk_flags({tag, " R9 after hold"});
    end else begin
      wdt_tmo = 1'b1;
      @(negedge clk);
      wdt_tmo = 1'b0;
      if (ctx == 1) begin
        e_to = 1'b1; e_pdf = 1'b1;
        chk("R5 warm", int'(warm_rst), 1);
        chk("R5 no cold", int'(cold_rst), 0);
        chk_flags("R5");
        halt_req = 1'b1;              // R8: ignored during start-up hold
        wait_core(1'b0, 1'b1, n, bad);
        halt_req = 1'b0;
        chk("R5 R8 wake edges", n, SU);
        chk("R5 warm held", bad, 0);
      end else begin
        e_to = 1'b1;
        chk("R4 cold", int'(cold_rst), 1);
        chk_flags("R4");
        wait_core(1'b1, 1'b0, n, bad);
        chk("R4 restart edges", n, 1);
      end
    end
    chk("R10 running core_en", int'(core_en), 1);
    chk("R10 running cold", int'(cold_rst), 0);
  endtask

  initial begin
    int n, bad;
    por_n = 1'b0; ext_rst_n = 1'b1; wdt_tmo = 1'b0; halt_req = 1'b0;
    repeat (3) @(negedge clk);
    chk("R2 reset cold", int'(cold_rst), 1);
    chk("R2 reset core_en", int'(core_en), 0);
    chk("R2 reset warm", int'(warm_rst), 0);
    chk_flags("R2 reset");
    wdt_tmo = 1'b1;                    // R9: ignored during power-up
    por_n = 1'b1;
    wait_core(1'b1, 1'b0, n, bad);
    wdt_tmo = 1'b0;
    chk("R2 R9 power-up edges", n, SU + 2);
    chk("R2 power-up cold", bad, 0);
    chk_flags("R9 power-up");

    por_n = 1'b0; ext_rst_n = 1'b0;
    @(negedge clk);
    por_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R2 pin low core_en", int'(core_en), 0);
    chk("R2 pin low cold", int'(cold_rst), 1);
    ext_rst_n = 1'b1;
    wait_core(1'b1, 1'b0, n, bad);
    chk("R2 pin release edges", n, SU + 2);

    for (int rep = 0; rep < 3; rep++)
      for (int c = 0; c < 2; c++)
        for (int ev = 0; ev < 3; ev++)
          scenario((rep + c) % 2, ev);

    por_n = 1'b0;
    @(negedge clk);
    e_to = 1'b0; e_pdf = 1'b0;
    chk_flags("R2 flags cleared");
    por_n = 1'b1;
    wait_core(1'b1, 1'b0, n, bad);
    chk("R2 second power-up", n, SU + 2);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nvec++; nerr++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

endmodule